// File: doc/BRIEF.md
# Row-Structured Wavefront Lane Permute

This block is the cross-lane data sharing stage in front of a vector arithmetic unit. It works on a 64-lane wavefront. The wavefront is split into four rows of sixteen lanes, and each row is split into four banks of four lanes. Each accepted operation takes one lane vector and a control code. The code selects one pattern: a permute inside each quad, a mirror, a shift or rotate inside a row, a one-lane move across the whole wave, a broadcast from one row to the rows after it, a share of one lane across its row, or an XOR-indexed fetch. Each destination lane then takes the value of the source lane it selects. The result is written to a register one clock after the request.

Three things limit each destination write: a row enable mask, a bank enable mask, and the execution mask of the destination lane. A lane that is not enabled keeps its previous destination value, which arrives on `dst_old`. A source is invalid if it falls past an edge of a row or of the wave, if it lies outside the active half in 32-lane mode, or if it is an inactive lane and the fetch-inactive flag is clear. For an invalid source, the boundary flag chooses the result: zero, or the old destination value. A small two-state machine tracks whether the output register holds a fresh result. In state `ST_EMPTY`, a request (`in_valid`) moves it to `ST_FULL`. In `ST_FULL`, a cycle with no request moves it back to `ST_EMPTY`. A request while in `ST_FULL` keeps it in `ST_FULL`.

Top module: `wave_lane_permute`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_data` holds the result. When `in_valid` is low, `out_valid` drops after the edge and `out_data` keeps its value. Reset clears `out_valid` and `out_data`.
- R2: Op code 0 is the quad permute. Destination lane d reads lane (d - d%4) + s. Here s is the 2-bit field `op_arg[2*(d%4)+1 : 2*(d%4)]`.
- R3: Op code 1 reverses the sixteen lanes of each row: position p reads position 15-p. Op code 2 reverses each group of eight lanes.
- R4: Let a be `op_arg[3:0]` and p the position in the row. Op code 3 (row shift left) reads position p+a. Op code 4 (row shift right) reads position p-a. Both treat a source outside the row as invalid. Op code 5 (row rotate right) reads position (p-a) mod 16. An amount of 0 leaves every lane reading itself.
- R5: Op code 6 makes lane d read lane d+1, and op code 8 makes lane d read lane d-1. A source past the wave edge is invalid. Op code 7 reads lane (d+1) mod N, and op code 9 reads lane (d-1) mod N, where N is the active lane count.
- R6: Op code 10 gives every lane of row r (r of 1 or more) the value of lane 16r-1, and row 0 has an invalid source. Op code 11 gives rows 2 and 3 the value of lane 31, and rows 0 and 1 have an invalid source.
- R7: Op code 12 gives every lane of a row the value of position a of that row. Op code 13 makes position p read position p XOR a of the same row.
- R8: Lane d belongs to row d[5:4] and bank d[3:2]. A lane whose `row_mask` bit or `bank_mask` bit is 0 outputs its `dst_old` value.
- R9: A lane whose own `exec_mask` bit is 0 outputs its `dst_old` value.
- R10: An enabled lane with an invalid source outputs zero when `bound_zero` is 1, and its `dst_old` value when `bound_zero` is 0.
- R11: When `fetch_inactive` is 1, a source lane whose `exec_mask` bit is 0 supplies its value. When it is 0, such a source is invalid.
- R12: When `wave32` is 1, only lanes 0 to 31 exist. Lanes 32 to 63 output `dst_old`, and any source above lane 31 is invalid.
- R13: Op codes 14 and 15 make each lane read itself. The masks and the invalid-source policy still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request: capture a result this edge |
| op | input | 4 | Pattern select code (see R2 to R7, R13) |
| op_arg | input | 8 | Quad selectors or 4-bit amount/lane constant |
| lane_in | input | 2048 | Source lane vector, lane d in bits [32d+31:32d] |
| exec_mask | input | 64 | Per-lane execution mask |
| dst_old | input | 2048 | Previous destination lane values |
| row_mask | input | 4 | Per-row write enable |
| bank_mask | input | 4 | Per-bank write enable |
| bound_zero | input | 1 | Invalid source yields zero when set |
| fetch_inactive | input | 1 | Inactive source lanes still supply data when set |
| wave32 | input | 1 | 32-lane mode |
| out_valid | output | 1 | Output register holds a fresh result |
| out_data | output | 2048 | Result lane vector |

## Verification
The assertions run on every cycle and check properties that do not depend on the pattern. They check the one-cycle valid handshake, that data is held when there is no request, and that the whole vector falls back to `dst_old` when the row mask, the bank mask or the execution mask is all zero. They also check that the upper half stays untouched in 32-lane mode. Only the bench scenarios can show that each pattern routes the right source to the right lane. The same is true of the edge and wrap cases of the shifts and rotates, the boundary-zero and fetch-inactive policies on partly active masks, and the mixed row and bank masks. The bench checks these against its own lane-by-lane model.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

    // Pattern codes; numeric values are visible at the op port.
    typedef enum logic [3:0] {
        OP_QPERM   = 4'd0,
        OP_RMIRROR = 4'd1,
        OP_HMIRROR = 4'd2,
        OP_RSHL    = 4'd3,
        OP_RSHR    = 4'd4,
        OP_RROR    = 4'd5,
        OP_WSHL    = 4'd6,
        OP_WROL    = 4'd7,
        OP_WSHR    = 4'd8,
        OP_WROR    = 4'd9,
        OP_BC_ROW  = 4'd10,
        OP_BC_HALF = 4'd11,
        OP_RSHARE  = 4'd12,
        OP_RXOR    = 4'd13,
        OP_RSV14   = 4'd14,
        OP_RSV15   = 4'd15
    } perm_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

    localparam int QUAD = 4;

endpackage

// File: rtl/lperm_src_map.sv
module lperm_src_map
    import lperm_pkg::*;
#(
    parameter int LANES = 64,
    parameter int ROW_W = 16,
    parameter int ARG_W = 8,
    localparam int IDX_W = $clog2(LANES),
    localparam int AMT_W = $clog2(ROW_W)
) (
    input  perm_op_e                    op,
    input  logic [ARG_W-1:0]            op_arg,
    input  logic                        wave32,
    output logic [LANES-1:0][IDX_W-1:0] src_idx,
    output logic [LANES-1:0]            edge_bad
);

    localparam int HALF_ROW = ROW_W / 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int P     = i % ROW_W;
        localparam int BASE  = i - P;
        localparam int RIDX  = i / ROW_W;
        localparam int QP    = i % QUAD;
        localparam int QBASE = i - QP;
        localparam int HP    = i % HALF_ROW;

        logic [IDX_W-1:0] idx_l;
        logic             bad_l;

        always_comb begin
            int s;
            int amt;
            int nact;
            logic b;
            amt  = int'(op_arg[AMT_W-1:0]);
            nact = wave32 ? (LANES / 2) : LANES;
            b    = 1'b0;
            s    = i;
            unique case (op)
                OP_QPERM:   s = QBASE + int'(op_arg[2*QP +: 2]);
                OP_RMIRROR: s = BASE + ROW_W - 1 - P;
                OP_HMIRROR: s = i - HP + HALF_ROW - 1 - HP;
                OP_RSHL: begin
                    s = i + amt;
                    b = (P + amt) >= ROW_W;
                end
                OP_RSHR: begin
                    s = i - amt;
                    b = (P - amt) < 0;
                end
                OP_RROR:    s = BASE + ((P - amt + ROW_W) % ROW_W);
                OP_WSHL: begin
                    s = i + 1;
                    b = (i + 1) >= nact;
                end
                OP_WROL:    s = ((i + 1) == nact) ? 0 : i + 1;
                OP_WSHR: begin
                    s = i - 1;
                    b = (i == 0);
                end
                OP_WROR:    s = (i == 0) ? nact - 1 : i - 1;
                OP_BC_ROW: begin
                    s = BASE - 1;
                    b = (RIDX == 0);
                end
                OP_BC_HALF: begin
                    s = 2 * ROW_W - 1;
                    b = (RIDX < 2);
                end
                OP_RSHARE:  s = BASE + amt;
                OP_RXOR:    s = BASE + (P ^ amt);
                OP_RSV14, OP_RSV15: s = i;
                default:    s = i;
            endcase
            if (s < 0 || s >= nact) begin
                b = 1'b1;
            end
            bad_l = b;
            idx_l = b ? IDX_W'(i) : IDX_W'(s);
        end

        assign src_idx[i]  = idx_l;
        assign edge_bad[i] = bad_l;
    end

endmodule

// File: rtl/lperm_lane_sel.sv
module lperm_lane_sel #(
    parameter int LANES = 64,
    parameter int ROW_W = 16,
    parameter int BANK_W = 4,
    parameter int DW = 32,
    localparam int IDX_W = $clog2(LANES),
    localparam int ROWS = LANES / ROW_W,
    localparam int BANKS = ROW_W / BANK_W
) (
    input  logic [LANES*DW-1:0]         lane_in,
    input  logic [LANES*DW-1:0]         dst_old,
    input  logic [LANES-1:0][IDX_W-1:0] src_idx,
    input  logic [LANES-1:0]            edge_bad,
    input  logic [LANES-1:0]            exec_mask,
    input  logic [ROWS-1:0]             row_mask,
    input  logic [BANKS-1:0]            bank_mask,
    input  logic                        bound_zero,
    input  logic                        fetch_inactive,
    input  logic                        wave32,
    output logic [LANES*DW-1:0]         next_data
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int RIDX  = i / ROW_W;
        localparam int BIDX  = (i % ROW_W) / BANK_W;
        localparam bit UPPER = (i >= LANES / 2);

        logic [DW-1:0] src_v;
        logic [DW-1:0] old_v;
        logic          src_live;
        logic          invalid;
        logic          wen;

        assign src_v    = lane_in[src_idx[i]*DW +: DW];
        assign old_v    = dst_old[i*DW +: DW];
        assign src_live = exec_mask[src_idx[i]] | fetch_inactive;
        assign invalid  = edge_bad[i] | ~src_live;
        assign wen      = row_mask[RIDX] & bank_mask[BIDX] & exec_mask[i]
                          & ~(wave32 & UPPER);

        assign next_data[i*DW +: DW] = !wen    ? old_v :
                                       invalid ? (bound_zero ? '0 : old_v) :
                                                 src_v;
    end

endmodule

// File: rtl/wave_lane_permute.sv
module wave_lane_permute
    import lperm_pkg::*;
#(
    parameter int LANES = 64,
    parameter int ROW_W = 16,
    parameter int BANK_W = 4,
    parameter int DW = 32,
    parameter int ARG_W = 8,
    localparam int IDX_W = $clog2(LANES),
    localparam int ROWS = LANES / ROW_W,
    localparam int BANKS = ROW_W / BANK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3:0]          op,
    input  logic [ARG_W-1:0]    op_arg,
    input  logic [LANES*DW-1:0] lane_in,
    input  logic [LANES-1:0]    exec_mask,
    input  logic [LANES*DW-1:0] dst_old,
    input  logic [ROWS-1:0]     row_mask,
    input  logic [BANKS-1:0]    bank_mask,
    input  logic                bound_zero,
    input  logic                fetch_inactive,
    input  logic                wave32,
    output logic                out_valid,
    output logic [LANES*DW-1:0] out_data
);

    out_state_e                 state_q, state_d;
    logic [LANES-1:0][IDX_W-1:0] src_idx;
    logic [LANES-1:0]           edge_bad;
    logic [LANES*DW-1:0]        next_data;
    perm_op_e                   op_e;

    assign op_e = perm_op_e'(op);

    lperm_src_map #(
        .LANES(LANES), .ROW_W(ROW_W), .ARG_W(ARG_W)
    ) u_map (
        .op      (op_e),
        .op_arg  (op_arg),
        .wave32  (wave32),
        .src_idx (src_idx),
        .edge_bad(edge_bad)
    );

    lperm_lane_sel #(
        .LANES(LANES), .ROW_W(ROW_W), .BANK_W(BANK_W), .DW(DW)
    ) u_sel (
        .lane_in       (lane_in),
        .dst_old       (dst_old),
        .src_idx       (src_idx),
        .edge_bad      (edge_bad),
        .exec_mask     (exec_mask),
        .row_mask      (row_mask),
        .bank_mask     (bank_mask),
        .bound_zero    (bound_zero),
        .fetch_inactive(fetch_inactive),
        .wave32        (wave32),
        .next_data     (next_data)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;
            ST_FULL:  if (!in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (in_valid) begin
            out_data <= next_data;
        end
    end

    assign out_valid = (state_q == ST_FULL);

endmodule

// File: rtl/wave_lane_permute_chk.sv
module wave_lane_permute_chk #(
    parameter int LANES = 64,
    parameter int ROW_W = 16,
    parameter int BANK_W = 4,
    parameter int DW = 32,
    localparam int ROWS = LANES / ROW_W,
    localparam int BANKS = ROW_W / BANK_W,
    localparam int HALF_BITS = (LANES / 2) * DW
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [LANES-1:0]    exec_mask,
    input logic [LANES*DW-1:0] dst_old,
    input logic [ROWS-1:0]     row_mask,
    input logic [BANKS-1:0]    bank_mask,
    input logic                wave32,
    input logic                out_valid,
    input logic [LANES*DW-1:0] out_data
);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    p_rows_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && row_mask == '0) |=> out_data == $past(dst_old));

    p_banks_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bank_mask == '0) |=> out_data == $past(dst_old));

    p_exec_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exec_mask == '0) |=> out_data == $past(dst_old));

    p_upper_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wave32) |=>
            out_data[LANES*DW-1:HALF_BITS] == $past(dst_old[LANES*DW-1:HALF_BITS]));

endmodule

bind wave_lane_permute wave_lane_permute_chk #(
    .LANES(LANES), .ROW_W(ROW_W), .BANK_W(BANK_W), .DW(DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .exec_mask(exec_mask),
    .dst_old  (dst_old),
    .row_mask (row_mask),
    .bank_mask(bank_mask),
    .wave32   (wave32),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/wave_lane_permute_test.sv
`timescale 1ns/1ps
module wave_lane_permute_test;

    localparam int NL = 64;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [3:0]        op = '0;
    logic [7:0]        op_arg = '0;
    logic [NL*DW-1:0]  lane_in = '0;
    logic [NL-1:0]     exec_mask = '0;
    logic [NL*DW-1:0]  dst_old = '0;
    logic [3:0]        row_mask = '0;
    logic [3:0]        bank_mask = '0;
    logic              bound_zero = 1'b0;
    logic              fetch_inactive = 1'b0;
    logic              wave32 = 1'b0;
    logic              out_valid;
    logic [NL*DW-1:0]  out_data;

    int n_checks = 0;
    int n_fail = 0;
    logic mdl_valid = 1'b0;
    logic [DW-1:0] g_in[NL];
    logic [DW-1:0] g_old[NL];
    logic [DW-1:0] exp_l[NL];

    always #2.5 clk = ~clk;

    wave_lane_permute uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .op_arg(op_arg),
        .lane_in(lane_in), .exec_mask(exec_mask), .dst_old(dst_old),
        .row_mask(row_mask), .bank_mask(bank_mask), .bound_zero(bound_zero),
        .fetch_inactive(fetch_inactive), .wave32(wave32),
        .out_valid(out_valid), .out_data(out_data)
    );

    // valid model, compared on every clock (R1)
    always @(posedge clk) mdl_valid <= rst_n ? in_valid : 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (out_valid !== mdl_valid) begin
                n_fail++;
                $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, mdl_valid);
            end
        end
    end

    function automatic logic [DW-1:0] model_lane(int d);
        int r = d / 16;
        int p = d % 16;
        int amt = int'(op_arg) % 16;
        int n_act = wave32 ? 32 : 64;
        int src = d;
        bit bad = 0;
        bit wr;
        case (int'(op))
            0:  src = d - d % 4 + ((int'(op_arg) >> (2 * (d % 4))) & 3);
            1:  src = 16 * r + 15 - p;
            2:  src = d - d % 8 + 7 - d % 8;
            3:  if (p + amt > 15) bad = 1; else src = d + amt;
            4:  if (p - amt < 0) bad = 1; else src = d - amt;
            5:  src = 16 * r + (p - amt + 16) % 16;
            6:  src = d + 1;
            7:  src = (d + 1) % n_act;
            8:  src = d - 1;
            9:  src = (d - 1 + n_act) % n_act;
            10: if (r == 0) bad = 1; else src = 16 * r - 1;
            11: if (r < 2) bad = 1; else src = 31;
            12: src = 16 * r + amt;
            13: src = 16 * r + (p ^ amt);
            default: src = d;
        endcase
        if (!bad && (src < 0 || src >= n_act)) bad = 1;
        wr = row_mask[r] && bank_mask[p / 4] && exec_mask[d] && (d < n_act);
        if (!wr) return g_old[d];
        if (bad || (!exec_mask[src] && !fetch_inactive)) return bound_zero ? '0 : g_old[d];
        return g_in[src];
    endfunction

    task automatic load_data(int seed);
        for (int k = 0; k < NL; k++) begin
            g_in[k]  = 32'hA000_0000 | (seed << 8) | k;
            g_old[k] = 32'hD000_0000 | (seed << 8) | k;
            lane_in[k*DW +: DW] = g_in[k];
            dst_old[k*DW +: DW] = g_old[k];
        end
    endtask

    task automatic run(input int o, input int a, input string tag);
        int bad_lane;
        @(negedge clk);
        op = 4'(o);
        op_arg = 8'(a);
        in_valid = 1'b1;
        #0.1;
        for (int k = 0; k < NL; k++) exp_l[k] = model_lane(k);
        @(negedge clk);
        in_valid = 1'b0;
        n_checks++;
        bad_lane = -1;
        for (int k = NL - 1; k >= 0; k--)
            if (out_data[k*DW +: DW] !== exp_l[k]) bad_lane = k;
        if (bad_lane >= 0) begin
            n_fail++;
            $display("FAIL %s op=%0d lane %0d actual=%h expected=%h", tag, o, bad_lane,
                     out_data[bad_lane*DW +: DW], exp_l[bad_lane]);
        end
    endtask

    task automatic defaults();
        exec_mask = '1;
        row_mask = 4'hF;
        bank_mask = 4'hF;
        bound_zero = 1'b0;
        fetch_inactive = 1'b0;
        wave32 = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        defaults();
        load_data(1);
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_fail++;
            $display("FAIL R1 reset actual=%b/%h expected=0/0", out_valid, out_data[31:0]);
        end
        rst_n = 1'b1;

        run(0, 8'b00_01_10_11, "R2 quad reverse");
        run(0, 8'b10_10_00_01, "R2 quad mixed");
        run(1, 0, "R3 row mirror");
        run(2, 0, "R3 half mirror");
        load_data(2);
        run(3, 3, "R4 row shl 3");
        bound_zero = 1'b1;
        run(3, 15, "R4 R10 row shl 15 zero");
        run(4, 5, "R4 R10 row shr 5 zero");
        bound_zero = 1'b0;
        run(4, 5, "R4 R10 row shr 5 keep");
        run(5, 7, "R4 row ror 7");
        run(3, 0, "R4 shift amount 0");
        bound_zero = 1'b1;
        run(6, 0, "R5 wave shl");
        run(7, 0, "R5 wave rol");
        run(8, 0, "R5 wave shr");
        run(9, 0, "R5 wave ror");
        run(10, 0, "R6 bcast row");
        run(11, 0, "R6 bcast half");
        run(12, 9, "R7 row share 9");
        run(13, 5, "R7 row xor 5");

        // hold: no request, data stable (R1)
        @(negedge clk);
        n_checks++;
        for (int k = 0; k < NL; k++)
            if (out_data[k*DW +: DW] !== exp_l[k]) begin
                n_fail++;
                $display("FAIL R1 hold lane %0d actual=%h expected=%h", k,
                         out_data[k*DW +: DW], exp_l[k]);
                break;
            end

        load_data(3);
        row_mask = 4'b1010;
        bank_mask = 4'b0110;
        run(5, 2, "R8 row/bank masks");
        row_mask = 4'h0;
        run(1, 0, "R8 rows all off");
        defaults();
        exec_mask = 64'h0F0F_3C3C_FF00_A5A5;
        bound_zero = 1'b1;
        run(5, 4, "R9 R10 R11 exec partial zero");
        bound_zero = 1'b0;
        run(12, 3, "R9 R10 R11 exec partial keep");
        fetch_inactive = 1'b1;
        run(5, 4, "R11 fetch inactive");
        run(13, 10, "R11 fetch inactive xor");
        defaults();
        wave32 = 1'b1;
        bound_zero = 1'b1;
        run(7, 0, "R12 R5 rol wave32");
        run(6, 0, "R12 shl wave32");
        run(11, 0, "R12 bcast half wave32");
        defaults();
        exec_mask = 64'hFFFF_FFFF_FFFF_FFFE;
        bound_zero = 1'b1;
        run(14, 0, "R13 reserved 14");
        run(15, 0, "R13 reserved 15");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule